// File: doc/BRIEF.md
# Privileged Status Register with Compare Flags

This block holds the 16-bit processor status word of a small integer core and applies every update the core makes to it. The word is split into a low byte and a high byte. Any program may write the low byte. The high byte holds the mode, stack-select, trace-pending and interrupt-enable bits, and a write to it takes effect only while the core is in supervisor mode. A write to the high byte from user mode is dropped and is reported on a one-cycle fault output.

A compare request carries two 32-bit operands. It sets the equal flag, the signed-less flag and the unsigned-less flag, each by asking whether the second operand relates to the first in that way. An end-of-instruction pulse drives the trace logic. When tracing is on and no trace is pending, the pulse raises a one-cycle trace-trap request and marks a trace as pending, so each instruction is trapped at most once. An interrupt or trap entry pulse clears the stack-select bit and the pending mark. A qualifier output tells the interrupt logic whether maskable interrupts may be taken.

Top module: `psr_core`

## Requirements
- R1: After reset the status word is 0x0000 (supervisor mode), and trace_trap and priv_fault are 0.
- R2: A write with wr_mask[0]=1 loads the low byte in either mode, one cycle later. Bit 0 is carry, bit 1 is trace enable, bit 2 is unsigned-less, bit 5 is the general flag, bit 6 is equal and bit 7 is signed-less. Bits 3 and 4 always read 0.
- R3: A write with wr_mask[1]=1 while bit 8 (user mode) is 0 loads the high byte. Bit 8 is user mode, bit 9 is stack select, bit 10 is trace pending and bit 11 is interrupt enable. Bits 12 to 15 always read 0.
- R4: A write with wr_mask[1]=1 while bit 8 is 1 leaves bits 15:8 unchanged and sets priv_fault for exactly the next cycle. The low-byte part of the same write still takes effect.
- R5: A compare sets bit 6 to 1 when cmp_b equals cmp_a, and to 0 otherwise.
- R6: A compare sets bit 7 to 1 when cmp_b is less than cmp_a as two's-complement numbers, and to 0 otherwise.
- R7: A compare sets bit 2 to 1 when cmp_b is less than cmp_a as unsigned numbers, and to 0 otherwise. A compare overrides a low-byte write of bits 2, 6 and 7 in the same cycle.
- R8: irq_accept equals bit 11. When it is 1 maskable interrupts are accepted, and when it is 0 only the non-maskable interrupt is.
- R9: instr_end while bit 1 is 1 and bit 10 is 0 sets trace_trap for exactly the next cycle and sets bit 10.
- R10: instr_end while bit 10 is 1 raises no trace_trap.
- R11: irq_entry clears bits 9 and 10 one cycle later. It overrides a same-cycle write or trace update of those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_mask | input | 2 | Byte select: bit 0 low byte, bit 1 high byte |
| wr_data | input | 16 | Write data |
| cmp_en | input | 1 | Compare request |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| irq_entry | input | 1 | Interrupt or trap entry pulse |
| instr_end | input | 1 | End-of-instruction pulse |
| status | output | 16 | Current status word |
| trace_trap | output | 1 | One-cycle trace trap request |
| irq_accept | output | 1 | Maskable interrupts may be accepted |
| priv_fault | output | 1 | One-cycle flag for a high-byte write dropped in user mode |

## Verification
The hardest case to reach is a write to the high byte from user mode. Once bit 8 is set, no port can clear it short of reset, so the fault path can only be tested after the supervisor-only cases are done. The stimulus therefore runs all supervisor-mode work first. It then has the supervisor write itself into user mode, probes the dropped write and the surviving low-byte half, and resets before the next group of cases. The trace pair is taken through trap, suppression and re-arm by irq_entry. The compare is given operand pairs whose signed and unsigned orders disagree.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = PSR_W / BYTE_W;
  localparam int B_CARRY = 0;
  localparam int B_TRACE = 1;
  localparam int B_ULT   = 2;
  localparam int B_FLAG  = 5;
  localparam int B_EQ    = 6;
  localparam int B_SLT   = 7;
  localparam int B_USER  = 8;
  localparam int B_STK   = 9;
  localparam int B_PEND  = 10;
  localparam int B_IEN   = 11;
  localparam logic [PSR_W-1:0] IMPL_MASK = 16'h0FE7;
endpackage

// File: rtl/psr_compare.sv
module psr_compare #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output logic            eq,
  output logic            lt_s,
  output logic            lt_u
);
  always_comb begin
    eq   = (op_b == op_a);
    lt_u = (op_b < op_a);
    lt_s = ($signed(op_b) < $signed(op_a));
  end
endmodule

// File: rtl/psr_write.sv
module psr_write
  import psr_pkg::*;
(
  input  logic [PSR_W-1:0]  cur,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] wr_mask,
  input  logic [PSR_W-1:0]  wr_data,
  output logic [PSR_W-1:0]  wr_next,
  output logic              fault
);
  localparam int TOP = NBYTES - 1;
  logic user_mode;
  assign user_mode = cur[B_USER];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic allow;
    if (g == 0) begin : g_open
      assign allow = 1'b1;
    end else begin : g_priv
      assign allow = ~user_mode;
    end
    always_comb begin
      if (wr_en && wr_mask[g] && allow)
        wr_next[g*BYTE_W +: BYTE_W] = wr_data[g*BYTE_W +: BYTE_W] & IMPL_MASK[g*BYTE_W +: BYTE_W];
      else
        wr_next[g*BYTE_W +: BYTE_W] = cur[g*BYTE_W +: BYTE_W];
    end
  end

  assign fault = wr_en && wr_mask[TOP] && user_mode;
endmodule

// File: rtl/psr_trace.sv
module psr_trace (
  input  logic trace_on,
  input  logic pending,
  input  logic instr_end,
  output logic trap_req
);
  assign trap_req = instr_end && trace_on && !pending;
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_mask,
  input  logic [15:0]       wr_data,
  input  logic              cmp_en,
  input  logic [OP_W-1:0]   cmp_a,
  input  logic [OP_W-1:0]   cmp_b,
  input  logic              irq_entry,
  input  logic              instr_end,
  output logic [15:0]       status,
  output logic              trace_trap,
  output logic              irq_accept,
  output logic              priv_fault
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [PSR_W-1:0] psr_q, psr_d, wr_next;
  logic             trap_d, fault_d, trap_q, fault_q;
  logic             cmp_eq, cmp_lts, cmp_ltu;
  logic             psr_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  psr_compare #(.OP_W(OP_W)) u_cmp (
    .op_a(cmp_a), .op_b(cmp_b), .eq(cmp_eq), .lt_s(cmp_lts), .lt_u(cmp_ltu)
  );

  psr_write u_wr (
    .cur(psr_q), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .wr_next(wr_next), .fault(fault_d)
  );

  psr_trace u_trc (
    .trace_on(psr_q[B_TRACE]), .pending(psr_q[B_PEND]),
    .instr_end(instr_end), .trap_req(trap_d)
  );

  assign psr_ce = wr_en | cmp_en | irq_entry | trap_d;

  always_comb begin
    psr_d = wr_next;
    if (cmp_en) begin
      psr_d[B_EQ]  = cmp_eq;
      psr_d[B_SLT] = cmp_lts;
      psr_d[B_ULT] = cmp_ltu;
    end
    if (trap_d)    psr_d[B_PEND] = 1'b1;
    if (irq_entry) begin
      psr_d[B_STK]  = 1'b0;
      psr_d[B_PEND] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      psr_q   <= '0;
      trap_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (psr_ce) psr_q <= psr_d;
      trap_q  <= trap_d;
      fault_q <= fault_d;
    end
  end

  assign status     = psr_q;
  assign trace_trap = trap_q;
  assign priv_fault = fault_q;
  assign irq_accept = psr_q[B_IEN];
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        wr_en,
  input logic [1:0]  wr_mask,
  input logic        cmp_en,
  input logic [31:0] cmp_a,
  input logic [31:0] cmp_b,
  input logic        irq_entry,
  input logic        instr_end,
  input logic [15:0] status,
  input logic        trace_trap,
  input logic        priv_fault
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    status[15:12] == 4'h0 && status[4:3] == 2'b00);
  // R4
  user_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_mask[1] && status[8] && !irq_entry && !instr_end)
      |=> (status[15:8] == $past(status[15:8])) && priv_fault);
  // R5
  cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_en |=> status[6] == ($past(cmp_b) == $past(cmp_a)));
  // R7
  cmp_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_en |=> status[2] == ($past(cmp_b) < $past(cmp_a)));
  // R10
  trace_once_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (instr_end && status[10]) |=> !trace_trap);
  // R11
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_entry |=> !status[9] && !status[10]);
endmodule

bind psr_core psr_core_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .wr_en(wr_en), .wr_mask(wr_mask),
  .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b), .irq_entry(irq_entry),
  .instr_end(instr_end), .status(status), .trace_trap(trace_trap),
  .priv_fault(priv_fault)
);

// File: tb/tb_psr_core.sv
module tb_psr_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, cmp_en, irq_entry, instr_end;
  logic [1:0]  wr_mask;
  logic [15:0] wr_data;
  logic [31:0] cmp_a, cmp_b;
  logic [15:0] status;
  logic        trace_trap, irq_accept, priv_fault;

  always #2.5 clk = ~clk;

  psr_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b), .irq_entry(irq_entry),
    .instr_end(instr_end), .status(status), .trace_trap(trace_trap),
    .irq_accept(irq_accept), .priv_fault(priv_fault)
  );

  typedef struct {
    logic [15:0] psr;
    logic        trap;
    logic        fault;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] m_psr;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_mask = 0; wr_data = 0; cmp_en = 0; cmp_a = 0; cmp_b = 0;
    irq_entry = 0; instr_end = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_psr = 16'h0000;
    // R1 reset state
    check("R1 status", {16'h0, status}, 32'h0);
    check("R1 trap/fault", {30'h0, trace_trap, priv_fault}, 32'h0);
  endtask

  // driver: applies one cycle of stimulus, pushes the expected outcome
  task automatic step(input logic we, input logic [1:0] msk, input logic [15:0] d,
                      input logic ce, input logic [31:0] a, input logic [31:0] b,
                      input logic irq, input logic iend, input string tag);
    exp_t e;
    logic [15:0] nx;
    logic trap, flt;
    wr_en = we; wr_mask = msk; wr_data = d; cmp_en = ce; cmp_a = a; cmp_b = b;
    irq_entry = irq; instr_end = iend;
    nx = m_psr;
    if (we && msk[0]) nx[7:0] = d[7:0] & 8'hE7;
    if (we && msk[1] && !m_psr[8]) nx[15:8] = d[15:8] & 8'h0F;
    flt = we && msk[1] && m_psr[8];
    if (ce) begin
      nx[6] = (b == a);
      nx[7] = ($signed(b) < $signed(a));
      nx[2] = (b < a);
    end
    trap = iend && m_psr[1] && !m_psr[10];
    if (trap) nx[10] = 1'b1;
    if (irq) begin nx[9] = 1'b0; nx[10] = 1'b0; end
    m_psr = nx;
    e.psr = nx; e.trap = trap; e.fault = flt; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  // monitor: compares each result one step after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " status"}, {16'h0, status}, {16'h0, e.psr});
        check({e.tag, " trace_trap"}, {31'h0, trace_trap}, {31'h0, e.trap});
        check({e.tag, " priv_fault"}, {31'h0, priv_fault}, {31'h0, e.fault});
        check({e.tag, " irq_accept R8"}, {31'h0, irq_accept}, {31'h0, e.psr[11]});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 low byte write, reserved bits dropped
    step(1, 2'b01, 16'hFFFF, 0, 0, 0, 0, 0, "R2 low all ones");
    step(1, 2'b01, 16'h0021, 0, 0, 0, 0, 0, "R2 low pattern");
    // R3 supervisor high write, upper nibble dropped
    step(1, 2'b10, 16'hFE00, 0, 0, 0, 0, 0, "R3 high write");
    step(1, 2'b10, 16'h0800, 0, 0, 0, 0, 0, "R8 enable irq");
    // R5 R6 R7 compares
    step(0, 0, 0, 1, 32'd5, 32'd5, 0, 0, "R5 equal");
    step(0, 0, 0, 1, 32'd1, 32'hFFFF_FFFF, 0, 0, "R6 signed less only");
    step(0, 0, 0, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, "R7 unsigned less only");
    step(0, 0, 0, 1, 32'd3, 32'd9, 0, 0, "R5 greater");
    step(1, 2'b01, 16'h00C4, 1, 32'd9, 32'd3, 0, 0, "R7 compare beats write");
    // R9 R10 R11 trace
    step(1, 2'b11, 16'h0A02, 0, 0, 0, 0, 0, "R9 trace on stk set");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9 first trap");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R10 suppressed");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R11 entry clears");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9 rearmed trap");
    step(1, 2'b10, 16'h0200, 0, 0, 0, 1, 1, "R11 entry beats write");
    step(1, 2'b10, 16'h0000, 0, 0, 0, 0, 0, "R8 disable irq");
    // R4 user mode
    step(1, 2'b10, 16'h0100, 0, 0, 0, 0, 0, "R3 enter user");
    step(1, 2'b11, 16'h0E21, 0, 0, 0, 0, 0, "R4 dropped high");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4 fault one cycle");
    do_reset();
    step(1, 2'b11, 16'hFFFF, 0, 0, 0, 0, 0, "R3 reserved zero");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule